// File: doc/BRIEF.md
# Frame-rate outer-loop gain controller

This block closes a slow automatic gain loop around a receive chain. Once per radar frame a single-cycle strobe arrives together with a flag that says whether any sample in the finished frame clipped. The block then moves a 7-bit common gain code. After a clipped frame it cuts the gain hard. After a clean frame it raises the gain gently, but only once a hold-off window has drained. The code it produces goes to whatever logic programs the amplifier.

Whether the loop runs at all is set by a host request line. That line is only believed when two consecutive frame strobes see the same level, so a one-frame glitch cannot switch the loop on or off. The block also counts clipped frames. A separate clear input restarts the hold-off and the event count without touching the configured steps, limits or the present gain.

Top module: `frame_agc`

## Requirements
- R1: After reset, `gain_code` is 30, `agc_on` is 0 and `sat_events` is 0.
- R2: State changes only in a cycle where `frame_tick` (or `loop_clear`) is 1. In any other cycle, `sat_in`, `enable_req` and all configuration inputs have no effect on any output.
- R3: On each frame, `enable_req` is stored as the previous sample, which resets to 0. `agc_on` takes the value of `enable_req` only if it equals the previous sample. A request that lasts a single frame therefore leaves `agc_on` unchanged.
- R4: While the loop is off, a frame leaves `gain_code`, `sat_events` and the hold-off count unchanged.
- R5: On an enabled frame with `sat_in`=1, `gain_code` becomes `gain_code - step_down`. If that would fall below `gain_min` (underflow included), it becomes `gain_min` instead.
- R6: An enabled saturated frame loads the hold-off count with `holdoff_frames`. On an enabled clean frame with a nonzero count, the count drops by 1 and the gain holds. On an enabled clean frame with a zero count, `gain_code` becomes min(`gain_code + step_up`, `gain_max`).
- R7: `sat_events` increments on every enabled saturated frame and sticks at 2^CNT_W-1.
- R8: `loop_clear`=1 zeroes the hold-off count and `sat_events` and keeps `gain_code`, `agc_on` and the stored enable sample. It overrides a `frame_tick` in the same cycle, and that frame is dropped.
- R9: The enable decision for a frame is made before the gain update of that same frame. The frame that confirms an enable is already regulated, and the frame that confirms a disable is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle frame strobe |
| sat_in | input | 1 | Clipping seen in the finished frame |
| enable_req | input | 1 | Host loop enable request |
| loop_clear | input | 1 | Clear hold-off and event count |
| step_down | input | GAIN_W | Decrement on a saturated frame |
| step_up | input | GAIN_W | Increment on a recovered frame |
| gain_min | input | GAIN_W | Lower gain limit |
| gain_max | input | GAIN_W | Upper gain limit |
| holdoff_frames | input | HOLD_W | Clean frames to wait before raising |
| gain_code | output | GAIN_W | Current common gain code |
| agc_on | output | 1 | Confirmed loop enable |
| sat_events | output | CNT_W | Saturated-frame counter |

## Verification
The assertions assume that `gain_min` does not exceed `gain_max`, that the configuration inputs only change while no strobe is present, and that the gain code lies inside the limits whenever a saturated frame is applied. The stimulus changes the limits only between strobes. It lowers `gain_max` only after the gain is already at or below the new value, so every frame sees a consistent range. Strobes are always one cycle wide, with idle cycles between them in which the flag and request lines are deliberately toggled.

// File: rtl/frame_agc.sv
module frame_agc #(
  parameter int GAIN_W = 7,
  parameter int CNT_W = 8,
  parameter int HOLD_W = 4,
  parameter int START_GAIN = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              sat_in,
  input  logic              enable_req,
  input  logic              loop_clear,
  input  logic [GAIN_W-1:0] step_down,
  input  logic [GAIN_W-1:0] step_up,
  input  logic [GAIN_W-1:0] gain_min,
  input  logic [GAIN_W-1:0] gain_max,
  input  logic [HOLD_W-1:0] holdoff_frames,
  output logic [GAIN_W-1:0] gain_code,
  output logic              agc_on,
  output logic [CNT_W-1:0]  sat_events
);

  localparam int WW = GAIN_W + 1;

  logic              en_prev;
  logic              en_next;
  logic [HOLD_W-1:0] hold_cnt;
  logic [WW-1:0]     low_bound, raised;
  logic [GAIN_W-1:0] gain_dn, gain_up;
  logic              run;

  assign en_next   = (enable_req == en_prev) ? enable_req : agc_on;
  assign run       = frame_tick && !loop_clear;
  assign low_bound = {1'b0, gain_min} + {1'b0, step_down};
  assign raised    = {1'b0, gain_code} + {1'b0, step_up};
  assign gain_dn   = ({1'b0, gain_code} < low_bound) ? gain_min : gain_code - step_down;
  assign gain_up   = (raised > {1'b0, gain_max}) ? gain_max : raised[GAIN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_prev <= 1'b0;
      agc_on  <= 1'b0;
    end else if (run) begin
      en_prev <= enable_req;
      agc_on  <= en_next;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_code <= GAIN_W'(START_GAIN);
      hold_cnt  <= '0;
    end else if (loop_clear) begin
      hold_cnt  <= '0;
    end else if (frame_tick && en_next) begin
      if (sat_in) begin
        gain_code <= gain_dn;
        hold_cnt  <= holdoff_frames;
      end else if (hold_cnt != '0) begin
        hold_cnt  <= hold_cnt - 1'b1;
      end else begin
        gain_code <= gain_up;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || loop_clear)
      sat_events <= '0;
    else if (frame_tick && en_next && sat_in && !(&sat_events))
      sat_events <= sat_events + 1'b1;
  end

endmodule

module frame_agc_chk #(
  parameter int GAIN_W = 7,
  parameter int CNT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_tick,
  input logic              sat_in,
  input logic              enable_req,
  input logic              loop_clear,
  input logic [GAIN_W-1:0] gain_min,
  input logic [GAIN_W-1:0] gain_max,
  input logic [GAIN_W-1:0] gain_code,
  input logic              agc_on,
  input logic [CNT_W-1:0]  sat_events
);

  p_idle_gain_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(gain_code));

  p_idle_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(agc_on));

  p_idle_events_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_tick && !loop_clear) |=> $stable(sat_events));

  p_rise_confirmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(agc_on) |-> $past(enable_req));

  p_fall_confirmed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(agc_on) |-> !$past(enable_req));

  p_off_holds_gain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick ##1 !agc_on) |-> $stable(gain_code));

  p_sat_not_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && sat_in && !loop_clear ##1 agc_on) |-> (gain_code <= $past(gain_code)));

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !loop_clear ##1 agc_on && !$stable(gain_code)) |->
      (gain_code >= gain_min && gain_code <= gain_max));

  p_event_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && sat_in && !loop_clear ##1 agc_on) |-> (sat_events != '0));

  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    loop_clear |=> (sat_events == '0) && $stable(gain_code));

endmodule

bind frame_agc frame_agc_chk #(.GAIN_W(GAIN_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .sat_in(sat_in),
  .enable_req(enable_req), .loop_clear(loop_clear), .gain_min(gain_min),
  .gain_max(gain_max), .gain_code(gain_code), .agc_on(agc_on),
  .sat_events(sat_events)
);

// File: tb/frame_agc_tb.sv
module frame_agc_tb;
  logic clk = 0, rst_n = 0;
  logic frame_tick = 0, sat_in = 0, enable_req = 0, loop_clear = 0;
  logic [6:0] step_down = 4, step_up = 1, gain_min = 0, gain_max = 127;
  logic [3:0] holdoff_frames = 4;
  logic [6:0] gain_code;
  logic       agc_on;
  logic [7:0] sat_events;

  int tests = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  int mg = 30, mo = 0, mp = 0, mh = 0, me = 0;

  always #4 clk = ~clk;

  frame_agc u_dut (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .sat_in(sat_in),
    .enable_req(enable_req), .loop_clear(loop_clear), .step_down(step_down),
    .step_up(step_up), .gain_min(gain_min), .gain_max(gain_max),
    .holdoff_frames(holdoff_frames), .gain_code(gain_code), .agc_on(agc_on),
    .sat_events(sat_events)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      mg = 30; mo = 0; mp = 0; mh = 0; me = 0;
    end else if (loop_clear) begin
      mh = 0; me = 0;
    end else if (frame_tick) begin
      if (int'(enable_req) == mp) mo = int'(enable_req);
      mp = int'(enable_req);
      if (mo == 1) begin
        if (sat_in) begin
          mg = (mg - int'(step_down) < int'(gain_min)) ? int'(gain_min) : mg - int'(step_down);
          mh = int'(holdoff_frames);
          if (me < 255) me = me + 1;
        end else if (mh > 0) begin
          mh = mh - 1;
        end else begin
          mg = (mg + int'(step_up) > int'(gain_max)) ? int'(gain_max) : mg + int'(step_up);
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check({tag, " gain"}, int'(gain_code), mg);
      check({tag, " on"}, int'(agc_on), mo);
      check({tag, " events"}, int'(sat_events), me);
    end
  end

  task automatic tick(bit s, bit e);
    @(negedge clk);
    frame_tick = 1; sat_in = s; enable_req = e;
    @(negedge clk);
    frame_tick = 0; sat_in = ~s; enable_req = ~e;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset gain", int'(gain_code), 30);
    check("R1 reset on", int'(agc_on), 0);
    check("R1 reset events", int'(sat_events), 0);

    tag = "R3";
    tick(0, 1);
    tick(0, 0);
    check("R3 single-frame request ignored", int'(agc_on), 0);

    tag = "R4";
    tick(1, 1);
    check("R4 disabled gain held", int'(gain_code), 30);
    check("R4 disabled events held", int'(sat_events), 0);

    tag = "R9";
    tick(1, 1);
    check("R9 confirming frame regulated on", int'(agc_on), 1);
    check("R5 saturated step 30->26", int'(gain_code), 26);
    check("R7 one event", int'(sat_events), 1);

    tag = "R2";
    @(negedge clk);
    sat_in = 1; enable_req = 0; step_down = 9;
    repeat (6) @(negedge clk);
    check("R2 idle gain", int'(gain_code), 26);
    check("R2 idle on", int'(agc_on), 1);
    step_down = 4;

    tag = "R6";
    for (int i = 0; i < 4; i++) tick(0, 1);
    check("R6 hold-off blocks rise", int'(gain_code), 26);
    tick(0, 1);
    check("R6 rise after hold-off", int'(gain_code), 27);
    tick(0, 1);
    check("R6 second rise", int'(gain_code), 28);

    tag = "R5";
    gain_min = 25;
    tick(1, 1);
    check("R5 clamp at min", int'(gain_code), 25);
    gain_min = 0;

    tag = "R6";
    gain_max = 27; step_up = 5;
    for (int i = 0; i < 5; i++) tick(0, 1);
    check("R6 clamp at max", int'(gain_code), 27);

    tag = "R8";
    tick(1, 1);
    @(negedge clk); loop_clear = 1;
    @(negedge clk); loop_clear = 0;
    @(negedge clk);
    check("R8 clear events", int'(sat_events), 0);
    check("R8 clear keeps gain", int'(gain_code), 23);
    check("R8 clear keeps on", int'(agc_on), 1);
    gain_max = 127; step_up = 1;
    tick(0, 1);
    check("R8 hold-off cleared, immediate rise", int'(gain_code), 24);

    @(negedge clk);
    frame_tick = 1; loop_clear = 1; sat_in = 1; enable_req = 1;
    @(negedge clk);
    frame_tick = 0; loop_clear = 0; sat_in = 0;
    @(negedge clk);
    check("R8 clear overrides strobe", int'(gain_code), 24);

    tag = "R9";
    tick(1, 0);
    check("R9 unconfirmed off still regulates", int'(gain_code), 20);
    tick(1, 0);
    check("R9 confirmed off frame not regulated", int'(gain_code), 20);
    check("R4 loop off", int'(agc_on), 0);

    tag = "R7";
    tick(0, 1);
    tick(0, 1);
    for (int i = 0; i < 300; i++) tick(1, 1);
    check("R7 events stick at max", int'(sat_events), 255);
    check("R5 gain floors at 0", int'(gain_code), 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule